// File: doc/BRIEF.md
# Phase correction pulse generator

This block removes a measured phase offset between a frequency synthesizer output and its reference clock by a short frequency excursion. When software or a sequencer asserts the start strobe, before data modulation begins, the block samples the current phase reading from the time-to-digital converter together with the desired phase. The offset is folded onto the quarter-turn periodicity of the interference, which leaves a signed correction of less than an eighth of a turn either way.

The correction is scaled into a frequency word. The arithmetic is a fixed-point multiply by 6250/256, which corresponds to a 1 Hz word LSB for a 10 µs pulse. That word is presented on two outputs, one for the reference frequency-word adder and one for the direct oscillator path of a two-point modulator. It stays there for exactly 260 reference cycles, which is 10 µs at 26 MHz. The loop integrates the pulse into a phase step equal to the correction. A one-cycle done flag marks the end of the pulse, and both words return to zero at the same time.

Top module: `pcp_comp_pulse`

## Requirements
- R1: While reset is asserted and after it is released, both frequency words are zero and done is low until a start is accepted.
- R2: Phases are unsigned 12-bit codes with 4096 codes per full turn. The correction code c is computed as follows. Take d = (target − measured) mod 4096. Keep r = d mod 1024 (one 90° period). If r ≥ 512, then c = r − 1024; otherwise c = r. This puts c in [−512, 511], which is [−45°, +45°).
- R3: The frequency word is floor((c·6250 + 128) / 256), a signed 16-bit two's-complement value. This is round-to-nearest with ties toward +∞.
- R4: The reference-path word and the oscillator-path word carry the same value in every cycle.
- R5: A start accepted at a clock edge makes the word appear in the next cycle. The word is held for exactly 260 consecutive cycles.
- R6: Done is high for exactly one cycle, the cycle right after the last pulse cycle. In that cycle and afterwards, both words are zero.
- R7: A start strobe raised while a pulse is in progress has no effect. The word, the pulse length and the done timing are unchanged, and no second pulse follows.
- R8: The phase inputs are sampled only at an accepted start. Changes to them during a pulse do not alter the word.
- R9: A start raised in the cycle where done is high is accepted. It begins a new pulse with no idle cycle between the two pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to sample phases and launch a correction pulse |
| phase_meas_i | input | 12 | Measured phase, unsigned fraction of a turn |
| phase_tgt_i | input | 12 | Desired phase, unsigned fraction of a turn |
| fcw_ref_o | output | 16 | Signed frequency offset for the reference frequency-word path |
| fcw_dco_o | output | 16 | Signed frequency offset for the direct oscillator path |
| done_o | output | 1 | One-cycle flag after the pulse ends |

## Verification
The bench records the cycle at which each accepted start lands. It expects the word in each of the next 260 cycles, then done with zero words in the following cycle, which is 261 cycles after the start edge. A scoreboard item carries the start cycle and the word computed from the wrap and rounding formulas. The monitor samples on the falling edge and compares every pulse cycle against that item. It checks done only in the one cycle where it is due and treats any activity outside a scheduled window as an error. Ignored starts push no item, so any reaction to them appears as a mismatch in that window or as an idle violation.

// File: rtl/pcp_pkg.sv
package pcp_pkg;
  localparam int PCP_PHASE_W      = 12;
  localparam int PCP_PERIOD_LOG2  = 2;    // 4 interference periods per turn
  localparam int PCP_FREQ_W       = 16;
  localparam int PCP_GAIN_Q       = 6250; // 1e5/4096 * 2^8
  localparam int PCP_GAIN_SHIFT   = 8;
  localparam int PCP_PULSE_CYCLES = 260;  // 10 us at 26 MHz

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } pcp_state_e;
endpackage

// File: rtl/pcp_phase_wrap.sv
module pcp_phase_wrap #(
  parameter int PHASE_W     = 12,
  parameter int PERIOD_LOG2 = 2,
  localparam int CORR_W     = PHASE_W - PERIOD_LOG2
) (
  input  logic [PHASE_W-1:0]       phase_meas_i,
  input  logic [PHASE_W-1:0]       phase_tgt_i,
  output logic signed [CORR_W-1:0] corr_o
);
  logic [PHASE_W-1:0] diff;

  // mod-turn subtraction; low bits are the position inside one period,
  // reading them as two's complement recentres to [-P/2, P/2)
  assign diff   = phase_tgt_i - phase_meas_i;
  assign corr_o = $signed(diff[CORR_W-1:0]);
endmodule

// File: rtl/pcp_freq_scale.sv
module pcp_freq_scale #(
  parameter int CORR_W     = 10,
  parameter int FREQ_W     = 16,
  parameter int GAIN_Q     = 6250,
  parameter int GAIN_SHIFT = 8,
  localparam int GAIN_W    = $clog2(GAIN_Q + 1),
  localparam int PROD_W    = CORR_W + GAIN_W + 1
) (
  input  logic signed [CORR_W-1:0] corr_i,
  output logic signed [FREQ_W-1:0] word_o
);
  localparam logic signed [PROD_W-1:0] GAIN_S = PROD_W'(GAIN_Q);
  localparam logic signed [PROD_W-1:0] W_MAX  = PROD_W'((64'sd1 <<< (FREQ_W-1)) - 1);
  localparam logic signed [PROD_W-1:0] W_MIN  = -W_MAX - PROD_W'(1);

  logic signed [PROD_W-1:0] corr_x;
  logic signed [PROD_W-1:0] prod;
  logic signed [PROD_W-1:0] scaled;

  assign corr_x = PROD_W'(corr_i);
  assign prod   = corr_x * GAIN_S;

  generate
    if (GAIN_SHIFT > 0) begin : g_round
      localparam logic signed [PROD_W-1:0] HALF = PROD_W'(64'sd1 <<< (GAIN_SHIFT-1));
      logic signed [PROD_W-1:0] rnd;
      assign rnd    = prod + HALF;
      assign scaled = rnd >>> GAIN_SHIFT;
    end else begin : g_plain
      assign scaled = prod;
    end
  endgenerate

  always_comb begin
    if (scaled > W_MAX)      word_o = W_MAX[FREQ_W-1:0];
    else if (scaled < W_MIN) word_o = W_MIN[FREQ_W-1:0];
    else                     word_o = scaled[FREQ_W-1:0];
  end
endmodule

// File: rtl/pcp_pulse_timer.sv
module pcp_pulse_timer
  import pcp_pkg::*;
#(
  parameter int PULSE_CYCLES = 260,
  localparam int CNT_W       = $clog2(PULSE_CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic accept_o,
  output logic active_o,
  output logic done_o
);
  pcp_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;

  assign accept_o = start_i && (state_q == ST_IDLE);
  assign active_o = (state_q == ST_RUN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            cnt_q   <= CNT_W'(PULSE_CYCLES);
            state_q <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (cnt_q == CNT_W'(1)) begin
            cnt_q   <= '0;
            state_q <= ST_IDLE;
            done_o  <= 1'b1;
          end else begin
            cnt_q <= cnt_q - CNT_W'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pcp_comp_pulse.sv
module pcp_comp_pulse
  import pcp_pkg::*;
#(
  parameter int PHASE_W      = PCP_PHASE_W,
  parameter int PERIOD_LOG2  = PCP_PERIOD_LOG2,
  parameter int FREQ_W       = PCP_FREQ_W,
  parameter int GAIN_Q       = PCP_GAIN_Q,
  parameter int GAIN_SHIFT   = PCP_GAIN_SHIFT,
  parameter int PULSE_CYCLES = PCP_PULSE_CYCLES
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic [PHASE_W-1:0]       phase_meas_i,
  input  logic [PHASE_W-1:0]       phase_tgt_i,
  output logic signed [FREQ_W-1:0] fcw_ref_o,
  output logic signed [FREQ_W-1:0] fcw_dco_o,
  output logic                     done_o
);
  localparam int CORR_W  = PHASE_W - PERIOD_LOG2;
  localparam int N_PATHS = 2;

  logic signed [CORR_W-1:0] corr;
  logic signed [FREQ_W-1:0] word_d;
  logic signed [FREQ_W-1:0] word_q;
  logic                     accept;
  logic                     pulse_act;
  logic [FREQ_W-1:0]        path_word [N_PATHS];

  pcp_phase_wrap #(
    .PHASE_W     (PHASE_W),
    .PERIOD_LOG2 (PERIOD_LOG2)
  ) u_wrap (
    .phase_meas_i (phase_meas_i),
    .phase_tgt_i  (phase_tgt_i),
    .corr_o       (corr)
  );

  pcp_freq_scale #(
    .CORR_W     (CORR_W),
    .FREQ_W     (FREQ_W),
    .GAIN_Q     (GAIN_Q),
    .GAIN_SHIFT (GAIN_SHIFT)
  ) u_scale (
    .corr_i (corr),
    .word_o (word_d)
  );

  pcp_pulse_timer #(
    .PULSE_CYCLES (PULSE_CYCLES)
  ) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .accept_o (accept),
    .active_o (pulse_act),
    .done_o   (done_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     word_q <= '0;
    else if (accept) word_q <= word_d;
  end

  // same offset onto both injection points of the two-point modulator
  generate
    for (genvar p = 0; p < N_PATHS; p++) begin : g_path
      assign path_word[p] = pulse_act ? word_q : '0;
    end
  endgenerate

  assign fcw_ref_o = path_word[0];
  assign fcw_dco_o = path_word[1];
endmodule

// File: rtl/pcp_comp_pulse_chk.sv
module pcp_comp_pulse_chk #(
  parameter int FREQ_W       = 16,
  parameter int PULSE_CYCLES = 260,
  localparam int CW          = $clog2(PULSE_CYCLES + 2)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [FREQ_W-1:0] fcw_ref_o,
  input logic [FREQ_W-1:0] fcw_dco_o,
  input logic              done_o,
  input logic              pulse_act
);
  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        run_cnt <= '0;
    else if (pulse_act) run_cnt <= run_cnt + CW'(1);
    else                run_cnt <= '0;
  end

  p_len_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> run_cnt == CW'(PULSE_CYCLES));

  p_accept_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pulse_act && start_i) |=> pulse_act);

  p_done_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (fcw_ref_o == '0 && fcw_dco_o == '0 && !pulse_act));

  p_word_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_act && $past(pulse_act)) |-> ($stable(fcw_ref_o) && $stable(fcw_dco_o)));

  p_busy_ignore_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_act && start_i) |=> ($stable(fcw_ref_o) || done_o));
endmodule

bind pcp_comp_pulse pcp_comp_pulse_chk #(
  .FREQ_W       (FREQ_W),
  .PULSE_CYCLES (PULSE_CYCLES)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .fcw_ref_o (fcw_ref_o),
  .fcw_dco_o (fcw_dco_o),
  .done_o    (done_o),
  .pulse_act (pulse_act)
);

// File: tb/pcp_comp_pulse_tb.sv
module pcp_comp_pulse_tb;
  localparam int CLK_PERIOD = 38;
  localparam int PULSE      = 260;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              start_i = 1'b0;
  logic [11:0]       phase_meas_i = '0;
  logic [11:0]       phase_tgt_i = '0;
  logic signed [15:0] fcw_ref_o;
  logic signed [15:0] fcw_dco_o;
  logic              done_o;

  pcp_comp_pulse u_dut (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .phase_meas_i (phase_meas_i),
    .phase_tgt_i  (phase_tgt_i),
    .fcw_ref_o    (fcw_ref_o),
    .fcw_dco_o    (fcw_dco_o),
    .done_o       (done_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  typedef struct {
    int    word;
    int    s;
    string tag;
  } item_t;

  item_t sb_q[$];
  item_t it;
  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  int word_bad = 0, path_bad = 0, done_early = 0, idle_bad = 0;
  int bad_act = 0;
  bit finished = 1'b0;

  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // word from R2 wrap and R3 rounding
  function automatic int exp_word(input int meas, input int tgt);
    int d = (tgt - meas) & 4095;
    int c = d & 1023;
    if (c >= 512) c = c - 1024;
    return (c * 6250 + 128) >>> 8;
  endfunction

  // monitor / scoreboard
  always @(negedge clk_i) begin
    if (rst_ni && !finished) begin
      if (sb_q.size() > 0 && cyc >= sb_q[0].s) begin
        it = sb_q[0];
        if (cyc <= it.s + PULSE - 1) begin
          if (int'(fcw_ref_o) != it.word) begin
            if (word_bad == 0) bad_act = int'(fcw_ref_o);
            word_bad++;
          end
          if (fcw_ref_o !== fcw_dco_o) path_bad++;
          if (done_o !== 1'b0) done_early++;
        end else begin
          chk(word_bad == 0, it.tag, "pulse word", bad_act, it.word);
          chk(path_bad == 0, "R4", "path mismatch cycles", path_bad, 0);
          chk(done_early == 0, "R5", "done inside pulse window", done_early, 0);
          chk(done_o === 1'b1, "R6", "done at cycle 261", int'(done_o), 1);
          chk(fcw_ref_o == 0 && fcw_dco_o == 0, "R6", "words after pulse",
              int'(fcw_ref_o), 0);
          void'(sb_q.pop_front());
          word_bad = 0; path_bad = 0; done_early = 0;
        end
      end else begin
        if (done_o !== 1'b0 || fcw_ref_o !== 0 || fcw_dco_o !== 0) idle_bad++;
      end
    end
  end

  // driver: called at a negedge, returns at the next negedge
  task automatic fire(input int meas, input int tgt, input string tag, input bit push);
    item_t n;
    start_i      = 1'b1;
    phase_meas_i = 12'(meas);
    phase_tgt_i  = 12'(tgt);
    if (push) begin
      n.word = exp_word(meas, tgt);
      n.s    = cyc + 1;
      n.tag  = tag;
      sb_q.push_back(n);
    end
    @(negedge clk_i);
    start_i = 1'b0;
    // R8: disturb phase inputs while the pulse runs
    phase_meas_i = 12'(meas + 777);
    phase_tgt_i  = 12'(tgt + 1234);
  endtask

  task automatic wait_idle();
    while (sb_q.size() > 0) @(negedge clk_i);
    repeat (2) @(negedge clk_i);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk(fcw_ref_o == 0 && fcw_dco_o == 0, "R1", "words in reset", int'(fcw_ref_o), 0);
    chk(done_o === 1'b0, "R1", "done in reset", int'(done_o), 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    chk(fcw_ref_o == 0 && done_o === 1'b0, "R1", "idle after reset", int'(fcw_ref_o), 0);

    fire(0, 0, "R2", 1'b1);            wait_idle();  // zero correction
    fire(0, 100, "R3", 1'b1);          wait_idle();  // +2441
    fire(100, 0, "R3", 1'b1);          wait_idle();  // -2441
    fire(0, 511, "R2", 1'b1);          wait_idle();  // top of range
    fire(0, 512, "R2", 1'b1);          wait_idle();  // folds to -512
    fire(300, 1324, "R2", 1'b1);       wait_idle();  // one full period -> 0
    fire(0, 1535, "R2", 1'b1);         wait_idle();  // wraps to 511
    fire(1, 0, "R3", 1'b1);            wait_idle();  // -1 -> -24
    fire(3000, 2900, "R2", 1'b1);      wait_idle();  // across turn

    // R7: start during pulse is ignored
    fire(0, 200, "R7", 1'b1);
    repeat (50) @(negedge clk_i);
    fire(5, 900, "R7", 1'b0);
    repeat (30) @(negedge clk_i);
    fire(9, 400, "R7", 1'b0);
    wait_idle();
    repeat (5) @(negedge clk_i);
    chk(fcw_ref_o == 0 && done_o === 1'b0, "R7", "no second pulse", int'(fcw_ref_o), 0);

    // R9: back-to-back start in the done cycle
    fire(10, 60, "R9", 1'b1);
    while (done_o !== 1'b1) @(negedge clk_i);
    fire(60, 10, "R9", 1'b1);
    wait_idle();

    chk(idle_bad == 0, "R7", "activity outside scheduled pulses", idle_bad, 0);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R5 actual=%0d expected=%0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule